// File: doc/BRIEF.md
# Periodic Square-Wave Channel

This block produces one square wave that begins at an absolute moment of a shared 64-bit nanosecond time base. Software loads a 64-bit start instant as two 32-bit halves, an enable flag and a period measured in reference clock ticks. Once the channel is enabled, the length is nonzero and the time input has reached the start instant, the output goes high. From then on it toggles every half period, counted in reference ticks, which gives a 50% duty wave.

Several copies sit side by side, one per output, and share the time bus and the reference tick. The register write port is a plain one-cycle strobe that is always accepted, so it has no back-pressure. The time input and the tick are sampled every clock and no handshake applies to them. A write to the start halves or to the length re-arms the channel. The output then stays low until the next start match.

Top module: `pgen_channel`

## Requirements
- R1: After reset the output is low, and all registers (start instant, enable, length) read as zero, so the output stays low even when only the enable is set.
- R2: The start instant is the 64-bit value {high word, low word}. While the channel is not running, the output is low. In the first clock in which enable=1, length≠0 and the time input is greater than or equal to the start instant (unsigned, all 64 bits), the channel starts, and the output is high after that clock edge.
- R3: With half = floor(length/2), or 1 when that is 0, the output starts high and toggles on the reference tick that completes `half` ticks since the start or since the last toggle.
- R4: Reference ticks that arrive before the start match have no effect on the phase. While the channel runs, the output changes only on a tick or a re-arm.
- R5: A length of zero keeps the output low whatever the time input is.
- R6: A write to address 0 (start low word), address 1 (start high word) or address 3 (length) stops the channel. The output is low after that edge, and the channel restarts only on a new match under R2.
- R7: Bit 0 of address 2 is the enable. Clearing it forces the output low from the next clock edge. A write to address 2 does not re-arm the channel or disturb its phase, so setting the bit again restores the wave where it stood.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 2 | Register address: 0 start low, 1 start high, 2 control, 3 length |
| wr_data | input | 32 | Register write data |
| time_ns | input | 64 | Shared nanosecond time base |
| ref_tick | input | 1 | One-cycle reference clock tick |
| wave_out | output | 1 | Generated square wave |

## Verification
A bad half-period count appears on the output as a toggle on the wrong tick. This shows up within one half period of the start and is visible at every toggle after it. A start comparison that ignores the upper word, or that fires one step early, makes the output rise a cycle too soon. This is checked at the exact boundary. A re-arm or gating fault leaves the output high in the cycle right after the write, where the sweep samples it. A phase lost through a control write shows in the first sample after re-enable.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [1:0] {
    REG_CMP_LO = 2'd0,
    REG_CMP_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_LEN    = 2'd3
  } pgen_reg_e;

  localparam int CTRL_EN_BIT = 0;
endpackage

// File: rtl/pgen_regs.sv
module pgen_regs
  import pgen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TIME_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TIME_W-1:0] cmp_val,
  output logic [LEN_W-1:0]  len_val,
  output logic              enable,
  output logic              rearm
);
  localparam int HI_W = TIME_W - DATA_W;

  logic [DATA_W-1:0] cmp_lo_q;
  logic [HI_W-1:0]   cmp_hi_q;
  logic [LEN_W-1:0]  len_q;
  logic              en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_lo_q <= '0;
      cmp_hi_q <= '0;
      len_q    <= '0;
      en_q     <= 1'b0;
    end else if (wr_en) begin
      case (pgen_reg_e'(wr_addr))
        REG_CMP_LO: cmp_lo_q <= wr_data;
        REG_CMP_HI: cmp_hi_q <= wr_data[HI_W-1:0];
        REG_CTRL:   en_q     <= wr_data[CTRL_EN_BIT];
        REG_LEN:    len_q    <= wr_data[LEN_W-1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    cmp_val = {cmp_hi_q, cmp_lo_q};
    len_val = len_q;
    enable  = en_q;
    rearm   = wr_en && (pgen_reg_e'(wr_addr) != REG_CTRL);
  end
endmodule

// File: rtl/pgen_start.sv
module pgen_start #(
  parameter int TIME_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic [TIME_W-1:0] time_ns,
  input  logic [TIME_W-1:0] cmp_val,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              enable,
  output logic              start_hit
);
  always_comb begin
    start_hit = enable && (len_val != '0) && (time_ns >= cmp_val);
  end
endmodule

// File: rtl/pgen_divider.sv
module pgen_divider #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm,
  input  logic             start_hit,
  input  logic             tick,
  input  logic [LEN_W-1:0] len_val,
  output logic             wave,
  output logic             running
);
  logic [LEN_W-1:0] half;
  logic [LEN_W-1:0] cnt_q;
  logic             wave_q;
  logic             run_q;

  always_comb begin
    half = len_val >> 1;
    if (half == '0) half = {{(LEN_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wave_q <= 1'b0;
      cnt_q  <= '0;
    end else if (rearm) begin
      run_q  <= 1'b0;
      wave_q <= 1'b0;
    end else if (!run_q) begin
      if (start_hit) begin
        run_q  <= 1'b1;
        wave_q <= 1'b1;
        cnt_q  <= half;
      end
    end else if (tick) begin
      if (cnt_q <= 1) begin
        wave_q <= ~wave_q;
        cnt_q  <= half;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign wave    = wave_q;
  assign running = run_q;

  assert_rearm_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (!wave_q && !run_q));
  assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && !rearm) |=> $stable(wave_q));
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !wave_q);
endmodule

// File: rtl/pgen_channel.sv
module pgen_channel #(
  parameter int DATA_W = 32,
  parameter int TIME_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TIME_W-1:0] time_ns,
  input  logic              ref_tick,
  output logic              wave_out
);
  logic [TIME_W-1:0] cmp_val;
  logic [LEN_W-1:0]  len_val;
  logic              enable;
  logic              rearm;
  logic              start_hit;
  logic              wave_raw;
  logic              running;

  pgen_regs #(.DATA_W(DATA_W), .TIME_W(TIME_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp_val(cmp_val), .len_val(len_val),
    .enable(enable), .rearm(rearm)
  );

  pgen_start #(.TIME_W(TIME_W), .LEN_W(LEN_W)) u_start (
    .time_ns(time_ns), .cmp_val(cmp_val), .len_val(len_val),
    .enable(enable), .start_hit(start_hit)
  );

  pgen_divider #(.LEN_W(LEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .start_hit(start_hit),
    .tick(ref_tick), .len_val(len_val), .wave(wave_raw), .running(running)
  );

  assign wave_out = wave_raw & enable;

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wave_out |-> (enable && (len_val != '0)));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && start_hit && !rearm) |=> running);
  assert_len_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (len_val == '0) |-> !wave_out);
endmodule

// File: tb/pgen_channel_bench.sv
module pgen_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] time_ns = '0;
  logic        ref_tick = 1'b0;
  logic        wave_out;

  int checks = 0;
  int errors = 0;
  int ticks = 0;
  int half = 1;
  bit done = 0;

  always #4 clk = ~clk;

  pgen_channel u_pgen_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .time_ns(time_ns), .ref_tick(ref_tick),
    .wave_out(wave_out)
  );

  task automatic chk(input bit exp, input string req);
    checks++;
    if (wave_out !== exp) begin
      errors++;
      $display("FAIL %s: wave_out=%0b expected %0b at %0t", req, wave_out, exp, $time);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic step(input bit t);
    ref_tick = t;
    @(posedge clk); #1;
    ref_tick = 1'b0;
  endtask

  function automatic bit model();
    return ((ticks / half) % 2) == 0;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(1'b0, "R1 reset");
    time_ns = '1;
    wr(2, 32'd1);
    step(1'b1); step(1'b0);
    chk(1'b0, "R1 zero length after reset");
    wr(2, 32'd0);

    for (int len = 1; len <= 9; len++) begin
      for (int sp = 1; sp <= 3; sp++) begin
        time_ns = 64'd50;
        wr(0, 32'd100); wr(1, 32'd0); wr(2, 32'd1); wr(3, len);
        half = (len / 2 == 0) ? 1 : len / 2;
        for (int k = 0; k < 3; k++) begin
          step(1'b1);
          chk(1'b0, "R4 ticks before start");
        end
        time_ns = 64'd99;
        step(1'b0);
        chk(1'b0, "R2 one below start");
        time_ns = 64'd100;
        step(1'b0);
        chk(1'b1, "R2 start match");
        ticks = 0;
        for (int i = 0; i < 24; i++) begin
          bit t = (i % sp) == 0;
          step(t);
          if (t) ticks++;
          chk(model(), "R3 half period toggle");
        end
      end
    end

    wr(2, 32'd0);
    chk(1'b0, "R7 disable gates");
    step(1'b0); step(1'b0);
    chk(1'b0, "R7 disabled stays low");
    wr(2, 32'd1);
    chk(model(), "R7 phase kept after control write");

    half = 4;
    wr(0, 32'd100);
    chk(1'b0, "R6 rearm forces low");
    step(1'b0);
    chk(1'b1, "R6 restart on match");
    for (int i = 1; i <= 4; i++) begin
      step(1'b1);
      chk(i == 4 ? 1'b0 : 1'b1, "R6 phase restarted");
    end

    wr(3, 32'd0);
    chk(1'b0, "R5 zero length");
    for (int i = 0; i < 5; i++) begin
      step(1'b1);
      chk(1'b0, "R5 zero length stays low");
    end

    wr(1, 32'd1); wr(0, 32'd0); wr(3, 32'd4);
    time_ns = 64'h0000_0000_FFFF_FFFF;
    for (int i = 0; i < 3; i++) begin
      step(1'b0);
      chk(1'b0, "R2 upper word compare");
    end
    time_ns = 64'h0000_0001_0000_0000;
    step(1'b0);
    chk(1'b1, "R2 upper word match");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule